// File: doc/BRIEF.md
# SRAM Panel Exerciser

This block lets a person drive an SRAM controller by hand. Eight slide switches provide one byte, and three push buttons decide what that byte means. The load button copies the byte into a staging register that holds write data. The write button uses the byte as a memory address and writes the staged data there. The read button uses the byte as an address, and the word that comes back is shown on eight LEDs.

The buttons are debounced upstream, so each press arrives as a single-cycle pulse. On the controller side, the block drives a one-cycle request strobe, a direction bit, an address and write data. It watches the controller's ready flag and its registered read data.

A request is started only when the controller reports ready and no earlier request is still in flight. Presses that arrive at other times are dropped.

Top module: `sram_panel`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ctl_mem` is 0 and `led_out` is 0. The staged write data resets to 0.
- R2: A `key_load` pulse stores `sw_in` in the staging register, whatever the state of `ctl_ready`. A later write carries that value, zero-extended to the data width, on `ctl_wdata`.
- R3: A `key_write` pulse in a cycle with `ctl_ready` high causes, in the next cycle, `ctl_mem`=1 and `ctl_rw`=0 (write). In the same cycle `ctl_addr` is `sw_in` zero-extended and `ctl_wdata` is the staged byte zero-extended.
- R4: A `key_read` pulse in a cycle with `ctl_ready` high causes, in the next cycle, `ctl_mem`=1 and `ctl_rw`=1 (read), with `ctl_addr` set to `sw_in` zero-extended.
- R5: `ctl_mem` is never high for two cycles in a row. Exactly one strobe is issued for each accepted press.
- R6: A write or read press is ignored if `ctl_ready` is low in that cycle. No strobe follows it, and memory is not changed.
- R7: After a read strobe, `ctl_ready` first goes low and then returns high. In the first cycle it is high again, the low byte of `ctl_rdata` is captured, and it appears on `led_out` in the next cycle. `led_out` changes at no other time, so it holds across writes.
- R8: If write and read are pressed in the same cycle, the read is issued and the write is dropped. This is the default, set by `READ_WINS`=1.
- R9: If load and write are pressed in the same cycle, the write carries the previously staged byte, and the new byte is staged for later writes.
- R10: Loading 0x41 and writing it to 0x0E, then loading 0x43 and writing it to 0x0F, then reading 0x0E and 0x0F shows 0x41 and then 0x43 on `led_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_in | input | SW_W | Switch byte: data for a load, or address for a read or write |
| key_load | input | 1 | Pulse that stages the switch byte as write data |
| key_write | input | 1 | Pulse that writes staged data at the switch address |
| key_read | input | 1 | Pulse that reads from the switch address |
| ctl_ready | input | 1 | Controller is idle and can accept a request |
| ctl_rdata | input | DATA_W | Controller's registered read data |
| ctl_mem | output | 1 | One-cycle request strobe |
| ctl_rw | output | 1 | Direction: 1 read, 0 write |
| ctl_addr | output | ADDR_W | Request address |
| ctl_wdata | output | DATA_W | Request write data |
| led_out | output | LED_W | Low byte of the last completed read |

## Verification
The bench builds the block with its defaults: an 8-bit switch field, an 18-bit address, 16-bit data, 8 LEDs, and read priority on simultaneous presses. These widths make the zero-extension of address and data observable in the upper bits, and the 256-word memory model covers the whole switch address range. The controller model in the bench takes two busy cycles per request, so the ready-low then ready-high handshake of R7 is exercised. The model can also be held busy on demand, which lets a dropped press be checked at the ports.

// File: rtl/panel_pkg.sv
package panel_pkg;
   typedef enum logic [1:0] {
      TRK_IDLE      = 2'd0,
      TRK_WAIT_BUSY = 2'd1,
      TRK_WAIT_DONE = 2'd2
   } trk_e;

   localparam logic DIR_READ  = 1'b1;
   localparam logic DIR_WRITE = 1'b0;
endpackage

// File: rtl/panel_stage.sv
module panel_stage #(
   parameter int SW_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [SW_W-1:0] din,
   output logic [SW_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= din;
   end
endmodule

// File: rtl/panel_issue.sv
module panel_issue
   import panel_pkg::*;
#(
   parameter int SW_W      = 8,
   parameter int ADDR_W    = 18,
   parameter int DATA_W    = 16,
   parameter bit READ_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_write,
   input  logic              key_read,
   input  logic              ready,
   input  logic              blocked,
   input  logic [SW_W-1:0]   sw,
   input  logic [SW_W-1:0]   staged,
   output logic              mem,
   output logic              rw,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] wdata
);
   logic want_rd, want_wr, go;

   generate
      if (READ_WINS) begin : g_read_first
         assign want_rd = key_read;
         assign want_wr = key_write & ~key_read;
      end else begin : g_write_first
         assign want_wr = key_write;
         assign want_rd = key_read & ~key_write;
      end
   endgenerate

   assign go = ready & ~blocked & (want_rd | want_wr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem   <= 1'b0;
         rw    <= DIR_READ;
         addr  <= '0;
         wdata <= '0;
      end else begin
         mem <= go;
         if (go) begin
            rw   <= want_rd ? DIR_READ : DIR_WRITE;
            addr <= ADDR_W'(sw);
            if (want_wr) wdata <= DATA_W'(staged);
         end
      end
   end
endmodule

// File: rtl/panel_show.sv
module panel_show
   import panel_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int LED_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mem,
   input  logic              rw,
   input  logic              ready,
   input  logic [DATA_W-1:0] rdata,
   output logic [LED_W-1:0]  led,
   output logic              pending
);
   trk_e state;

   assign pending = (state != TRK_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= TRK_IDLE;
         led   <= '0;
      end else begin
         unique case (state)
            TRK_IDLE:
               if (mem && rw == DIR_READ) state <= TRK_WAIT_BUSY;
            TRK_WAIT_BUSY:
               if (!ready) state <= TRK_WAIT_DONE;
            TRK_WAIT_DONE:
               if (ready) begin
                  led   <= rdata[LED_W-1:0];
                  state <= TRK_IDLE;
               end
            default: state <= TRK_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sram_panel.sv
module sram_panel #(
   parameter int SW_W      = 8,
   parameter int ADDR_W    = 18,
   parameter int DATA_W    = 16,
   parameter int LED_W     = 8,
   parameter bit READ_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SW_W-1:0]   sw_in,
   input  logic              key_load,
   input  logic              key_write,
   input  logic              key_read,
   input  logic              ctl_ready,
   input  logic [DATA_W-1:0] ctl_rdata,
   output logic              ctl_mem,
   output logic              ctl_rw,
   output logic [ADDR_W-1:0] ctl_addr,
   output logic [DATA_W-1:0] ctl_wdata,
   output logic [LED_W-1:0]  led_out
);
   generate
      if (SW_W > ADDR_W || SW_W > DATA_W) begin : g_bad_sw
         $error("switch width exceeds address or data width");
      end
      if (LED_W > DATA_W || LED_W < 1) begin : g_bad_led
         $error("LED width must be 1..DATA_W");
      end
   endgenerate

   logic [SW_W-1:0] staged;
   logic            read_pending;
   logic            blocked;

   assign blocked = ctl_mem | read_pending;

   panel_stage #(.SW_W(SW_W)) u_stage (
      .clk (clk), .rst_n (rst_n), .load (key_load), .din (sw_in), .q (staged)
   );

   panel_issue #(
      .SW_W(SW_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .READ_WINS(READ_WINS)
   ) u_issue (
      .clk (clk), .rst_n (rst_n), .key_write (key_write), .key_read (key_read),
      .ready (ctl_ready), .blocked (blocked), .sw (sw_in), .staged (staged),
      .mem (ctl_mem), .rw (ctl_rw), .addr (ctl_addr), .wdata (ctl_wdata)
   );

   panel_show #(.DATA_W(DATA_W), .LED_W(LED_W)) u_show (
      .clk (clk), .rst_n (rst_n), .mem (ctl_mem), .rw (ctl_rw),
      .ready (ctl_ready), .rdata (ctl_rdata), .led (led_out),
      .pending (read_pending)
   );
endmodule

// File: rtl/panel_chk.sv
module panel_chk #(
   parameter int SW_W   = 8,
   parameter int ADDR_W = 18,
   parameter int DATA_W = 16,
   parameter int LED_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctl_ready,
   input logic              ctl_mem,
   input logic              ctl_rw,
   input logic [ADDR_W-1:0] ctl_addr,
   input logic [DATA_W-1:0] ctl_wdata,
   input logic [LED_W-1:0]  led_out
);
   // R5
   mem_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_mem |=> !ctl_mem);

   // R6
   mem_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_mem |-> $past(ctl_ready));

   // R3
   write_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_mem && !ctl_rw) |-> ((ctl_addr >> SW_W) == '0 && (ctl_wdata >> SW_W) == '0));

   // R4
   read_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_mem && ctl_rw) |-> ((ctl_addr >> SW_W) == '0));

   // R7
   led_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(led_out) |-> $past(ctl_ready));
endmodule

bind sram_panel panel_chk #(
   .SW_W(SW_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LED_W(LED_W)
) u_panel_chk (
   .clk (clk), .rst_n (rst_n), .ctl_ready (ctl_ready), .ctl_mem (ctl_mem),
   .ctl_rw (ctl_rw), .ctl_addr (ctl_addr), .ctl_wdata (ctl_wdata),
   .led_out (led_out)
);

// File: tb/sram_panel_bench.sv
`timescale 1ns/1ps
module sram_panel_bench;
   localparam int SW_W = 8, ADDR_W = 18, DATA_W = 16, LED_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [SW_W-1:0] sw_in = '0;
   logic key_load = 0, key_write = 0, key_read = 0;
   logic ctl_ready, ctl_mem, ctl_rw;
   logic [DATA_W-1:0] ctl_rdata, ctl_wdata;
   logic [ADDR_W-1:0] ctl_addr;
   logic [LED_W-1:0] led_out;

   int n_cmp = 0, n_bad = 0, n_strobe = 0, run_len = 0, max_run = 0, cyc = 0;
   int exp_strobe = 0;
   logic hold_busy = 1'b0;

   always #4 clk = ~clk;

   sram_panel u_sram_panel (
      .clk (clk), .rst_n (rst_n), .sw_in (sw_in), .key_load (key_load),
      .key_write (key_write), .key_read (key_read), .ctl_ready (ctl_ready),
      .ctl_rdata (ctl_rdata), .ctl_mem (ctl_mem), .ctl_rw (ctl_rw),
      .ctl_addr (ctl_addr), .ctl_wdata (ctl_wdata), .led_out (led_out)
   );

   // controller model: two busy cycles per request
   logic [DATA_W-1:0] marr [256];
   int m_cnt = 0;
   logic m_rw;
   logic [7:0] m_addr;
   logic [DATA_W-1:0] m_wdata;
   initial begin
      for (int i = 0; i < 256; i++) marr[i] = '0;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         ctl_ready <= 1'b1; ctl_rdata <= '0; m_cnt <= 0;
      end else if (m_cnt != 0) begin
         m_cnt <= m_cnt - 1;
         if (m_cnt == 1) begin
            if (m_rw) ctl_rdata <= marr[m_addr];
            else marr[m_addr] <= m_wdata;
            ctl_ready <= 1'b1;
         end
      end else if (ctl_mem && ctl_ready) begin
         m_cnt <= 2; ctl_ready <= 1'b0;
         m_rw <= ctl_rw; m_addr <= ctl_addr[7:0]; m_wdata <= ctl_wdata;
      end else begin
         ctl_ready <= !hold_busy;
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst_n && ctl_mem) begin
         n_strobe <= n_strobe + 1;
         run_len <= run_len + 1;
         if (run_len + 1 > max_run) max_run <= run_len + 1;
      end else run_len <= 0;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   task automatic settle();
      repeat (8) @(negedge clk);
   endtask

   task automatic do_load(input logic [7:0] v);
      @(negedge clk); sw_in = v; key_load = 1;
      @(negedge clk); key_load = 0;
      settle();
   endtask

   task automatic do_write(input logic [7:0] a, input logic [7:0] exp_data);
      @(negedge clk); sw_in = a; key_write = 1;
      @(negedge clk); key_write = 0;
      exp_strobe++;
      check("R3 strobe", ctl_mem, 1);
      check("R3 rw", ctl_rw, 0);
      check("R3 addr", ctl_addr, {10'b0, a});
      check("R2 wdata", ctl_wdata, {8'b0, exp_data});
      settle();
   endtask

   task automatic do_read(input logic [7:0] a, input logic [7:0] exp_led, input string req);
      @(negedge clk); sw_in = a; key_read = 1;
      @(negedge clk); key_read = 0;
      exp_strobe++;
      check("R4 strobe", ctl_mem, 1);
      check("R4 rw", ctl_rw, 1);
      check("R4 addr", ctl_addr, {10'b0, a});
      settle();
      check(req, led_out, exp_led);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check("R1 mem in reset", ctl_mem, 0);
      check("R1 led in reset", led_out, 0);
      rst_n = 1;
      @(negedge clk);
      check("R1 mem after reset", ctl_mem, 0);
      check("R1 led after reset", led_out, 0);
   endtask

   task automatic t_sequence();
      do_load(8'h41); do_write(8'h0E, 8'h41);
      do_load(8'h43); do_write(8'h0F, 8'h43);
      do_read(8'h0E, 8'h41, "R10 read 0E");
      do_read(8'h0F, 8'h43, "R10 read 0F");
   endtask

   task automatic t_led_hold();
      do_load(8'h55); do_write(8'h20, 8'h55);
      check("R7 led holds across write", led_out, 8'h43);
      do_read(8'h20, 8'h55, "R7 led after read");
   endtask

   task automatic t_both_keys();
      // staged is 0x55; write to 0x0F must be dropped
      @(negedge clk); sw_in = 8'h0F; key_write = 1; key_read = 1;
      @(negedge clk); key_write = 0; key_read = 0;
      exp_strobe++;
      check("R8 read chosen", ctl_rw, 1);
      settle();
      check("R8 read data", led_out, 8'h43);
      do_read(8'h0F, 8'h43, "R8 write dropped");
   endtask

   task automatic t_load_and_write();
      @(negedge clk); sw_in = 8'h66; key_load = 1; key_write = 1;
      @(negedge clk); key_load = 0; key_write = 0;
      exp_strobe++;
      check("R9 old staged on write", ctl_wdata, 16'h0055);
      settle();
      do_write(8'h31, 8'h66);
      do_read(8'h66, 8'h55, "R9 write landed");
   endtask

   task automatic t_busy_ignored();
      int seen = 0;
      hold_busy = 1;
      repeat (2) @(negedge clk);
      do_load(8'h77);
      @(negedge clk); sw_in = 8'h40; key_write = 1;
      @(negedge clk); key_write = 0;
      for (int i = 0; i < 6; i++) begin
         if (ctl_mem) seen++;
         @(negedge clk);
      end
      check("R6 no strobe while busy", seen, 0);
      hold_busy = 0;
      settle();
      do_read(8'h40, 8'h00, "R6 memory untouched");
      do_write(8'h41, 8'h77);
      do_read(8'h41, 8'h77, "R2 load while busy kept");
   endtask

   initial begin
      t_reset();
      t_sequence();
      t_led_hold();
      t_both_keys();
      t_load_and_write();
      t_busy_ignored();
      settle();
      check("R5 strobe count", n_strobe, exp_strobe);
      check("R5 strobe length", max_run, 1);
      finish_run();
   end
endmodule